// File: doc/BRIEF.md
# Replica-Path Voltage Margin Monitor

This block measures the voltage margin of one comparator in a reduced-comparator decision-feedback receiver without a known test pattern. The live decision path picks, for every received bit, one comparator result through a lookup table. The table is indexed by the recent decision history. A second path copies that selection logic exactly, with one difference: a configured comparator is swapped for an extra comparator. The extra comparator's threshold and sampling phase are swept from outside the block. Each bit on which the two paths disagree counts as a pseudo-error.

A start pulse opens a measurement window. The block counts compared bits and disagreements until the programmed window length is reached, then freezes both counts and raises done. A window length of zero runs until the next start. An outside sweep engine reads the error count at each offset and phase setting and builds an effective eye from it. Both paths use the live decision history, so a disagreement can only appear on a bit whose decision came from the substituted comparator.

Top module: `margin_monitor`

## Requirements
- R1: After reset, both counts are zero, busy and done are low, and the output decision and the decision history are zero.
- R2: On each cycle with bitValid high, the live decision is slicerBits[k], where k is the 2-bit field selTable[2*h+1:2*h] and h is the history value (bit 0 = newest decision, bit 1 = the one before). The decision shifts into the history at the clock edge and appears on dataOut after that edge. When bitValid is low, the history and dataOut hold.
- R3: The replica decision uses the same table entry and the same live history. Input extraBit stands in for comparator s, where s is the captured substitute index. A bit is counted as an error when the two decisions differ.
- R4: A bit whose selected comparator index is not the captured substitute index never adds to the error count, whatever extraBit is.
- R5: A start pulse clears both counts and clears done. It captures substIdx and windowLen, and busy is high from the next cycle.
- R6: Changes to substIdx or windowLen while busy have no effect on the running window.
- R7: While busy, bitCount rises by one for each cycle with bitValid high. Cycles with bitValid low and cycles outside a window are not counted.
- R8: When bitCount reaches a nonzero captured window length, busy falls and done rises at the same edge. Both counts then hold until the next start.
- R9: A captured window length of zero keeps the window open indefinitely, and done stays low.
- R10: Both counts saturate at their all-ones value and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new measurement window |
| substIdx | input | IDX_W | Comparator replaced in the replica path, captured at start |
| windowLen | input | CNT_W | Number of bits per window, 0 = unlimited, captured at start |
| selTable | input | 2^NUM_TAPS*IDX_W | Comparator index for each history value |
| slicerBits | input | NUM_SLICERS | Main comparator outputs for the current bit |
| extraBit | input | 1 | Output of the offset comparator |
| bitValid | input | 1 | Current comparator outputs hold a bit |
| dataOut | output | 1 | Newest live decision |
| busy | output | 1 | Measurement window open |
| done | output | 1 | Window complete, counts frozen |
| errCount | output | CNT_W | Replica/live disagreements in the window |
| bitCount | output | CNT_W | Bits compared in the window |

## Verification
The hardest case to reach is a disagreement that must not be counted. The extra comparator differs from the substituted comparator, but the history steers the table to a different comparator. To reach it, the bench loads tables that route every history away from the substituted index, or onto it, and drives extraBit opposite to that comparator. Saturation cannot be reached with the default 32-bit counters within the run time. A second instance with 4-bit counters and an unlimited window reaches it in a few dozen bits.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // new window: zero counts, capture configuration
    logic count;   // this bit is inside an open window
    logic finish;  // this bit closes the window
  } ctlStrobe_t;
endpackage

// File: rtl/mm_select_path.sv
module mm_select_path #(
  parameter int NUM_SLICERS = 4,
  parameter int NUM_TAPS    = 2,
  parameter int IDX_W       = (NUM_SLICERS > 1) ? $clog2(NUM_SLICERS) : 1,
  localparam int HIST_N     = 2 ** NUM_TAPS
) (
  input  logic [NUM_SLICERS-1:0]  slicerBits,
  input  logic [HIST_N*IDX_W-1:0] selTable,
  input  logic [NUM_TAPS-1:0]     history,
  output logic                    decision,
  output logic [IDX_W-1:0]        selIdx
);
  always_comb begin
    selIdx = selTable[int'(history)*IDX_W +: IDX_W];
    if ({1'b0, selIdx} < (IDX_W+1)'(NUM_SLICERS))
      decision = slicerBits[selIdx];
    else
      decision = 1'b0;
  end
endmodule

// File: rtl/mm_control.sv
module mm_control
  import mm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bitValid,
  input  logic       windowHit,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  always_comb begin
    strobe.clear  = start;
    strobe.count  = busy & bitValid & ~start;
    strobe.finish = busy & bitValid & ~start & windowHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (strobe.clear) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (strobe.finish) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int NUM_SLICERS = 4,
  parameter int NUM_TAPS    = 2,
  parameter int CNT_W       = 32,
  parameter int IDX_W       = (NUM_SLICERS > 1) ? $clog2(NUM_SLICERS) : 1,
  localparam int HIST_N     = 2 ** NUM_TAPS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  input  logic                    bitValid,
  input  logic [IDX_W-1:0]        substIdx,
  input  logic [CNT_W-1:0]        windowLen,
  input  logic [HIST_N*IDX_W-1:0] selTable,
  input  logic [NUM_SLICERS-1:0]  slicerBits,
  input  logic                    extraBit,
  output logic                    windowHit,
  output logic                    dataOut,
  output logic [IDX_W-1:0]        mainSelIdx,
  output logic [IDX_W-1:0]        capIdx,
  output logic [CNT_W-1:0]        errCount,
  output logic [CNT_W-1:0]        bitCount
);
  localparam int NUM_PATHS = 2;  // 0 = live, 1 = replica
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_TAPS-1:0]    history;
  logic [CNT_W-1:0]       capWin;
  logic [NUM_SLICERS-1:0] pathBits [NUM_PATHS];
  logic                   pathDec  [NUM_PATHS];
  logic [IDX_W-1:0]       pathIdx  [NUM_PATHS];
  logic                   mismatch;

  // replica comparator vector: one position swapped for the extra comparator
  for (genvar i = 0; i < NUM_SLICERS; i++) begin : g_subst
    assign pathBits[0][i] = slicerBits[i];
    assign pathBits[1][i] = (capIdx == IDX_W'(i)) ? extraBit : slicerBits[i];
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    mm_select_path #(
      .NUM_SLICERS(NUM_SLICERS),
      .NUM_TAPS   (NUM_TAPS),
      .IDX_W      (IDX_W)
    ) u_sel (
      .slicerBits(pathBits[p]),
      .selTable  (selTable),
      .history   (history),
      .decision  (pathDec[p]),
      .selIdx    (pathIdx[p])
    );
  end

  assign mismatch   = pathDec[0] ^ pathDec[1];
  assign mainSelIdx = pathIdx[0];
  assign dataOut    = history[0];
  assign windowHit  = (capWin != '0) && (bitCount == capWin - CNT_W'(1));

  // live decision history, newest in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      history <= '0;
    else if (bitValid) begin
      if (NUM_TAPS > 1)
        history <= {history[NUM_TAPS-2:0], pathDec[0]};
      else
        history <= NUM_TAPS'(pathDec[0]);
    end
  end

  // configuration captured per window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIdx <= '0;
      capWin <= '0;
    end else if (strobe.clear) begin
      capIdx <= substIdx;
      capWin <= windowLen;
    end
  end

  // saturating window counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (strobe.clear) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (strobe.count) begin
      if (bitCount != CNT_MAX)
        bitCount <= bitCount + CNT_W'(1);
      if (mismatch && errCount != CNT_MAX)
        errCount <= errCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/margin_monitor.sv
module margin_monitor
  import mm_pkg::*;
#(
  parameter int NUM_SLICERS = 4,
  parameter int NUM_TAPS    = 2,
  parameter int CNT_W       = 32,
  localparam int IDX_W      = (NUM_SLICERS > 1) ? $clog2(NUM_SLICERS) : 1,
  localparam int HIST_N     = 2 ** NUM_TAPS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IDX_W-1:0]        substIdx,
  input  logic [CNT_W-1:0]        windowLen,
  input  logic [HIST_N*IDX_W-1:0] selTable,
  input  logic [NUM_SLICERS-1:0]  slicerBits,
  input  logic                    extraBit,
  input  logic                    bitValid,
  output logic                    dataOut,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        errCount,
  output logic [CNT_W-1:0]        bitCount
);
  ctlStrobe_t       strobe;
  logic             windowHit;
  logic [IDX_W-1:0] mainSelIdx;
  logic [IDX_W-1:0] capIdx;

  mm_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .bitValid (bitValid),
    .windowHit(windowHit),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  mm_datapath #(
    .NUM_SLICERS(NUM_SLICERS),
    .NUM_TAPS   (NUM_TAPS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitValid  (bitValid),
    .substIdx  (substIdx),
    .windowLen (windowLen),
    .selTable  (selTable),
    .slicerBits(slicerBits),
    .extraBit  (extraBit),
    .windowHit (windowHit),
    .dataOut   (dataOut),
    .mainSelIdx(mainSelIdx),
    .capIdx    (capIdx),
    .errCount  (errCount),
    .bitCount  (bitCount)
  );
endmodule

// File: rtl/margin_monitor_chk.sv
module margin_monitor_chk #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             bitValid,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] mainSelIdx,
  input logic [IDX_W-1:0] capIdx,
  input logic [CNT_W-1:0] errCount,
  input logic [CNT_W-1:0] bitCount
);
  // R5: a start opens a window on the next cycle with empty counts
  a_r5_start_opens: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done && bitCount == '0 && errCount == '0));

  // R4: a bit served by another comparator adds no error
  a_r4_other_slicer_clean: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitValid && !start && mainSelIdx != capIdx) |=> $stable(errCount));

  // R8: finished window holds its counts
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(errCount) && $stable(bitCount)));

  // R8: done and busy are never high together
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R10: counts never fall except through start
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (bitCount >= $past(bitCount) && errCount >= $past(errCount)));

  // R3: errors never outnumber compared bits
  a_r3_err_bounded: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= bitCount);

  // R7: outside a window the bit count holds
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(bitCount));
endmodule

bind margin_monitor margin_monitor_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .bitValid  (bitValid),
  .busy      (busy),
  .done      (done),
  .mainSelIdx(mainSelIdx),
  .capIdx    (capIdx),
  .errCount  (errCount),
  .bitCount  (bitCount)
);

// File: tb/tb_margin_monitor.sv
`timescale 1ns/1ps
module tb_margin_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  substIdx = '0;
  logic [31:0] windowLen = '0;
  logic [7:0]  selTable = 8'b11100100;
  logic [3:0]  slicerBits = '0;
  logic        extraBit = 1'b0;
  logic        bitValid = 1'b0;
  logic        dataOut, busy, done;
  logic [31:0] errCount, bitCount;
  logic        sDataOut, sBusy, sDone;
  logic [3:0]  sErr, sBits;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  logic [1:0]  mHist = '0;
  logic [1:0]  mIdx = '0;
  logic [31:0] mWin = '0;
  logic [31:0] mErr = '0;
  logic [31:0] mBits = '0;
  logic        mBusy = 1'b0;
  logic        mDone = 1'b0;
  logic        mOut = 1'b0;

  always #2.5 clk = ~clk;

  margin_monitor dut (
    .clk(clk), .rstN(rstN), .start(start), .substIdx(substIdx),
    .windowLen(windowLen), .selTable(selTable), .slicerBits(slicerBits),
    .extraBit(extraBit), .bitValid(bitValid), .dataOut(dataOut),
    .busy(busy), .done(done), .errCount(errCount), .bitCount(bitCount)
  );

  margin_monitor #(.CNT_W(4)) dutSat (
    .clk(clk), .rstN(rstN), .start(start), .substIdx(substIdx),
    .windowLen(4'd0), .selTable(selTable), .slicerBits(slicerBits),
    .extraBit(extraBit), .bitValid(bitValid), .dataOut(sDataOut),
    .busy(sBusy), .done(sDone), .errCount(sErr), .bitCount(sBits)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "bitCount", bitCount, mBits);
    chk(req, "errCount", errCount, mErr);
    chk(req, "busy", 32'(busy), 32'(mBusy));
    chk(req, "done", 32'(done), 32'(mDone));
    chk(req, "dataOut", 32'(dataOut), 32'(mOut));
  endtask

  task automatic startWin(input logic [1:0] idx, input logic [31:0] win);
    @(negedge clk);
    start = 1'b1; bitValid = 1'b0; substIdx = idx; windowLen = win;
    mIdx = idx; mWin = win; mErr = '0; mBits = '0; mBusy = 1'b1; mDone = 1'b0;
  endtask

  task automatic driveBit(input logic [3:0] s, input logic e, input logic v);
    logic [1:0] sel;
    logic mb, rb;
    @(negedge clk);
    start = 1'b0; slicerBits = s; extraBit = e; bitValid = v;
    sel = selTable[2*mHist +: 2];
    mb = s[sel];
    rb = (sel == mIdx) ? e : s[sel];
    if (v) begin
      if (mBusy) begin
        if (mBits != 32'hFFFF_FFFF) mBits++;
        if (mb != rb && mErr != 32'hFFFF_FFFF) mErr++;
        if (mWin != 0 && mBits == mWin) begin mBusy = 1'b0; mDone = 1'b1; end
      end
      mHist = {mHist[0], mb};
      mOut = mb;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0; bitValid = 1'b0;
  endtask

  // R1
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mHist = '0; mOut = 1'b0; mBusy = 1'b0; mDone = 1'b0; mErr = '0; mBits = '0;
    idle();
    checkAll("R1");
  endtask

  // R2: live decision follows table and history
  task automatic testSelection();
    selTable = 8'b11100100;  // h -> slicer h
    for (int i = 0; i < 12; i++) begin
      driveBit(4'((i * 7 + 3) % 16), i[0], 1'b1);
      idle();
      chk("R2", "dataOut", 32'(dataOut), 32'(mOut));
    end
    // bitValid low: decision holds
    driveBit(~{4{mOut}}, 1'b0, 1'b0);
    idle();
    chk("R2", "dataOut hold", 32'(dataOut), 32'(mOut));
  endtask

  // R3 + R8: every bit served by substituted slicer, extra opposite
  task automatic testAllErrors();
    selTable = {4{2'd2}};
    startWin(2'd2, 32'd8);
    for (int i = 0; i < 8; i++) begin
      logic [3:0] s;
      s = 4'((i * 5) % 16);
      driveBit(s, ~s[2], 1'b1);
    end
    idle();
    chk("R3", "errCount all", errCount, 32'd8);
    chk("R8", "bitCount", bitCount, 32'd8);
    chk("R8", "done", 32'(done), 32'd1);
    checkAll("R8");
  endtask

  // R4: substituted slicer never selected
  task automatic testNoSelect();
    selTable = {4{2'd0}};
    startWin(2'd3, 32'd10);
    for (int i = 0; i < 10; i++) begin
      logic [3:0] s;
      s = 4'(i * 3);
      driveBit(s, ~s[3], 1'b1);
    end
    idle();
    chk("R4", "errCount", errCount, 32'd0);
    checkAll("R4");
  endtask

  // R3: mixed table, model decides which bits disagree
  task automatic testMixed();
    selTable = 8'b01101100;
    startWin(2'd1, 32'd16);
    for (int i = 0; i < 16; i++)
      driveBit(4'((i * 11 + 1) % 16), i[1] ^ i[0], 1'b1);
    idle();
    checkAll("R3");
  endtask

  // R6 + R7: mid-window config change ignored, invalid bits not counted
  task automatic testMidChange();
    selTable = {4{2'd1}};
    startWin(2'd1, 32'd6);
    driveBit(4'b0010, 1'b0, 1'b1);
    driveBit(4'b0000, 1'b1, 1'b0);
    driveBit(4'b0000, 1'b1, 1'b1);
    substIdx = 2'd0; windowLen = 32'd2;
    driveBit(4'b0010, 1'b0, 1'b1);
    driveBit(4'b0010, 1'b1, 1'b0);
    idle();
    chk("R7", "bitCount", bitCount, 32'd3);
    chk("R6", "errCount", errCount, 32'd3);
    chk("R6", "busy", 32'(busy), 32'd1);
    driveBit(4'b0000, 1'b0, 1'b1);
    driveBit(4'b0000, 1'b0, 1'b1);
    driveBit(4'b0000, 1'b1, 1'b1);
    idle();
    chk("R6", "done at 6", 32'(done), 32'd1);
    checkAll("R6");
    // R8: after done more bits leave counts unchanged
    driveBit(4'b0000, 1'b1, 1'b1);
    driveBit(4'b0000, 1'b1, 1'b1);
    idle();
    chk("R8", "frozen bitCount", bitCount, 32'd6);
    chk("R8", "frozen errCount", errCount, 32'd4);
    // R5: start clears
    startWin(2'd1, 32'd6);
    idle();
    chk("R5", "cleared bitCount", bitCount, 32'd0);
    chk("R5", "cleared errCount", errCount, 32'd0);
    chk("R5", "busy", 32'(busy), 32'd1);
    chk("R5", "done", 32'(done), 32'd0);
  endtask

  // R9 + R10: unlimited window, saturation on narrow instance
  task automatic testUnlimited();
    selTable = {4{2'd2}};
    startWin(2'd2, 32'd0);
    for (int i = 0; i < 20; i++)
      driveBit(4'b0100, 1'b0, 1'b1);
    idle();
    chk("R9", "busy", 32'(busy), 32'd1);
    chk("R9", "done", 32'(done), 32'd0);
    chk("R9", "bitCount", bitCount, 32'd20);
    chk("R9", "errCount", errCount, 32'd20);
    chk("R10", "sat bits", 32'(sBits), 32'd15);
    chk("R10", "sat errs", 32'(sErr), 32'd15);
    chk("R10", "sat busy", 32'(sBusy), 32'd1);
  endtask

  initial begin
    testReset();
    testSelection();
    testAllErrors();
    testNoSelect();
    testMixed();
    testMidChange();
    testUnlimited();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule